// File: doc/BRIEF.md
# Bank Activate/Precharge Timing Tracker

This block sits beside the command scheduler of a DDR memory controller. It keeps the open/closed state of every bank and the timers that decide when that bank may next be opened, read, written or closed. Every cycle the scheduler offers one decoded command: an operation, a bank number and an auto-precharge bit. The block accepts the command if it is legal, updates the bank state, and publishes per-bank permission vectors for the next cycle. If the command is not legal, the block leaves all state unchanged and raises a one-cycle error flag.

The block checks four minimum delays. Row-to-column delay is the time from opening a bank to its first read or write. Minimum active time is the time from opening a bank to closing it. Precharge recovery is the time from closing a bank to opening it again. Bank-to-bank open spacing is the minimum gap between opens to any two banks. A read or write that carries the auto-precharge bit closes its bank without further commands. The close happens at a point computed from the CAS latency and the burst length, and it is postponed if the minimum active time has not yet elapsed. All delays are parameters counted in clock cycles. Commands are sampled on the rising clock edge, and a command "at cycle n" means the one sampled at edge n.

Top module: `bank_timing_tracker`

## Requirements
- R1: After reset:
  - every bank is closed;
  - every bit of `can_act_o` is 1;
  - `can_col_o` and `can_pre_o` are 0;
  - `cmd_err_o` is 0.
- R2: Activate (op 1) to a closed bank opens it. An activate to a bank that is open, or that is waiting for an auto-precharge, is illegal.
- R3: Read (op 2) and write (op 3) are legal only to an open bank, and no earlier than T_RCD cycles after that bank's activate.
- R4: Two activates, to any banks, must be at least T_RRD cycles apart. While this gap runs, every bit of `can_act_o` is 0.
- R5: A single-bank precharge (op 4 with `cmd_ap_i` = 0) is legal only when all of these hold:
  - the bank is open;
  - at least T_RAS cycles have passed since its activate;
  - at least BL/2 cycles have passed since its last read or write, which lets a precharge follow a read at the earliest point that does not cut the burst short.
- R6: After a bank's precharge begins, an activate to that bank must wait at least T_RP cycles.
- R7: Op 4 with `cmd_ap_i` = 1 closes every open bank at once, whatever the bank number. It is legal only if every open bank meets the R5 conditions and no bank is waiting for an auto-precharge. Banks that are already closed are not touched, so their recovery timer does not restart.
- R8: A read or write with `cmd_ap_i` = 1 moves the bank into an auto-precharge wait. The bank then closes on its own 2*CL + BL/2 - 1 cycles after the command. If T_RAS is not yet met by then, the close happens on the first cycle at which it is. While the bank waits, it rejects every command addressed to it.
- R9: Any command that breaks R2 to R8, and any opcode from 5 to 7, is illegal. An illegal command sets `cmd_err_o` for exactly the following cycle and leaves every bank and timer unchanged. Op 0 (no operation) never raises the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; commands sampled on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_op_i | input | 3 | Operation: 0 nop, 1 activate, 2 read, 3 write, 4 precharge |
| cmd_bank_i | input | BANK_W | Target bank |
| cmd_ap_i | input | 1 | Auto-precharge on read/write; all-bank select on precharge |
| bank_open_o | output | 2**BANK_W | Bank is open (including auto-precharge wait) |
| can_act_o | output | 2**BANK_W | Activate to this bank is legal now |
| can_col_o | output | 2**BANK_W | Read or write to this bank is legal now |
| can_pre_o | output | 2**BANK_W | Single-bank precharge to this bank is legal now |
| can_pre_all_o | output | 1 | All-bank precharge is legal now |
| cmd_err_o | output | 1 | Previous cycle's command was illegal |

## Verification
The bench walks a command sequence that hits each delay one cycle too early and then exactly on time. A counter loaded one cycle off would flip the error flag at one of those boundaries.

An auto-precharge is issued while the minimum active time is still running. A design that ignores this rule closes the bank a cycle early, and one that never closes the bank leaves the following activates rejected.

An all-bank precharge is issued while one bank is closed and recovered. If that bank's recovery timer were restarted, the activate that follows would be refused. A precharge issued one cycle after a read shows whether the burst guard is enforced. The closed-bank activate after a rejected command shows that no state leaked from the illegal command.

// File: rtl/bank_trk_pkg.sv
package bank_trk_pkg;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_RD  = 3'd2,
    OP_WR  = 3'd3,
    OP_PRE = 3'd4
  } cmd_op_e;

  typedef enum logic [1:0] {
    BK_IDLE,
    BK_OPEN,
    BK_APWAIT
  } bank_state_e;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/bank_trk_cnt.sv
// Loadable down-counter that stops at zero.
module bank_trk_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/bank_trk_bank.sv
// Per-bank state machine and timers. Strobes arrive already qualified as legal.
module bank_trk_bank
  import bank_trk_pkg::*;
#(
  parameter int unsigned W        = 4,
  parameter int unsigned T_RCD    = 3,
  parameter int unsigned T_RAS    = 7,
  parameter int unsigned T_RP     = 3,
  parameter int unsigned BURST    = 2,
  parameter int unsigned AP_DELAY = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic col_i,
  input  logic col_ap_i,
  input  logic pre_i,
  output logic open_o,
  output logic can_act_o,
  output logic can_col_o,
  output logic can_pre_o
);

  bank_state_e state_q, state_d;
  logic rcd_zero, ras_zero, rp_zero, col_zero, ap_zero;
  logic ap_fire, close;

  assign ap_fire = (state_q == BK_APWAIT) && ap_zero && ras_zero;
  assign close   = ((state_q == BK_OPEN) && pre_i) || ap_fire;

  bank_trk_cnt #(.W(W)) u_rcd (
    .clk_i, .rst_ni, .load_i(act_i), .load_val_i(W'(T_RCD - 1)), .zero_o(rcd_zero)
  );
  bank_trk_cnt #(.W(W)) u_ras (
    .clk_i, .rst_ni, .load_i(act_i), .load_val_i(W'(T_RAS - 1)), .zero_o(ras_zero)
  );
  bank_trk_cnt #(.W(W)) u_rp (
    .clk_i, .rst_ni, .load_i(close), .load_val_i(W'(T_RP - 1)), .zero_o(rp_zero)
  );
  bank_trk_cnt #(.W(W)) u_col (
    .clk_i, .rst_ni, .load_i(col_i), .load_val_i(W'(BURST - 1)), .zero_o(col_zero)
  );
  bank_trk_cnt #(.W(W)) u_ap (
    .clk_i, .rst_ni, .load_i(col_i && col_ap_i), .load_val_i(W'(AP_DELAY - 1)),
    .zero_o(ap_zero)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      BK_IDLE:   if (act_i) state_d = BK_OPEN;
      BK_OPEN: begin
        if (pre_i)                  state_d = BK_IDLE;
        else if (col_i && col_ap_i) state_d = BK_APWAIT;
      end
      BK_APWAIT: if (ap_fire) state_d = BK_IDLE;
      default:   state_d = BK_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= BK_IDLE;
    else         state_q <= state_d;
  end

  assign open_o    = (state_q != BK_IDLE);
  assign can_act_o = (state_q == BK_IDLE) && rp_zero;
  assign can_col_o = (state_q == BK_OPEN) && rcd_zero;
  assign can_pre_o = (state_q == BK_OPEN) && ras_zero && col_zero;

endmodule

// File: rtl/bank_timing_tracker.sv
module bank_timing_tracker
  import bank_trk_pkg::*;
#(
  parameter int unsigned BANK_W = 2,
  parameter int unsigned T_RCD  = 3,
  parameter int unsigned T_RAS  = 7,
  parameter int unsigned T_RP   = 3,
  parameter int unsigned T_RRD  = 2,
  parameter int unsigned CL     = 2,
  parameter int unsigned BL     = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [2:0]               cmd_op_i,
  input  logic [BANK_W-1:0]        cmd_bank_i,
  input  logic                     cmd_ap_i,
  output logic [(1<<BANK_W)-1:0]   bank_open_o,
  output logic [(1<<BANK_W)-1:0]   can_act_o,
  output logic [(1<<BANK_W)-1:0]   can_col_o,
  output logic [(1<<BANK_W)-1:0]   can_pre_o,
  output logic                     can_pre_all_o,
  output logic                     cmd_err_o
);

  localparam int unsigned N_BANK   = 1 << BANK_W;
  localparam int unsigned BURST    = (BL / 2 > 0) ? BL / 2 : 1;
  localparam int unsigned AP_DELAY = 2 * CL + BURST - 1;
  localparam int unsigned T_MAX    = max2(max2(max2(T_RCD, T_RAS), max2(T_RP, T_RRD)),
                                          max2(AP_DELAY, BURST));
  localparam int unsigned CNT_W    = $clog2(T_MAX + 1);

  logic [N_BANK-1:0] open_b, act_ok_b, col_ok_b, pre_ok_b;
  logic [N_BANK-1:0] act_stb, col_stb, pre_stb;
  logic rrd_zero, legal, is_act, is_col, is_pre, pre_all, err_q;

  assign is_act  = (cmd_op_i == OP_ACT);
  assign is_col  = (cmd_op_i == OP_RD) || (cmd_op_i == OP_WR);
  assign is_pre  = (cmd_op_i == OP_PRE);
  assign pre_all = &(~open_b | pre_ok_b);

  always_comb begin
    unique case (cmd_op_i)
      OP_NOP:       legal = 1'b1;
      OP_ACT:       legal = act_ok_b[cmd_bank_i] && rrd_zero;
      OP_RD, OP_WR: legal = col_ok_b[cmd_bank_i];
      OP_PRE:       legal = cmd_ap_i ? pre_all : pre_ok_b[cmd_bank_i];
      default:      legal = 1'b0;
    endcase
  end

  bank_trk_cnt #(.W(CNT_W)) u_rrd (
    .clk_i, .rst_ni, .load_i(legal && is_act), .load_val_i(CNT_W'(T_RRD - 1)),
    .zero_o(rrd_zero)
  );

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    logic hit;
    assign hit        = (cmd_bank_i == BANK_W'(b));
    assign act_stb[b] = legal && is_act && hit;
    assign col_stb[b] = legal && is_col && hit;
    assign pre_stb[b] = legal && is_pre && (cmd_ap_i ? open_b[b] : hit);

    bank_trk_bank #(
      .W(CNT_W), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP),
      .BURST(BURST), .AP_DELAY(AP_DELAY)
    ) u_bank (
      .clk_i, .rst_ni,
      .act_i     (act_stb[b]),
      .col_i     (col_stb[b]),
      .col_ap_i  (cmd_ap_i),
      .pre_i     (pre_stb[b]),
      .open_o    (open_b[b]),
      .can_act_o (act_ok_b[b]),
      .can_col_o (col_ok_b[b]),
      .can_pre_o (pre_ok_b[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= !legal;
  end

  assign bank_open_o   = open_b;
  assign can_act_o     = act_ok_b & {N_BANK{rrd_zero}};
  assign can_col_o     = col_ok_b;
  assign can_pre_o     = pre_ok_b;
  assign can_pre_all_o = pre_all;
  assign cmd_err_o     = err_q;

endmodule

// File: rtl/bank_timing_tracker_chk.sv
module bank_timing_tracker_chk
  import bank_trk_pkg::*;
#(
  parameter int unsigned BANK_W = 2,
  parameter int unsigned T_RCD  = 3,
  parameter int unsigned T_RP   = 3,
  parameter int unsigned T_RRD  = 2
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [2:0]             cmd_op_i,
  input logic [BANK_W-1:0]      cmd_bank_i,
  input logic                   cmd_ap_i,
  input logic [(1<<BANK_W)-1:0] bank_open_o,
  input logic [(1<<BANK_W)-1:0] can_act_o,
  input logic [(1<<BANK_W)-1:0] can_col_o,
  input logic [(1<<BANK_W)-1:0] can_pre_o,
  input logic                   can_pre_all_o,
  input logic                   cmd_err_o
);

  logic acc_act, acc_pre1, ok_now;
  assign acc_act  = (cmd_op_i == OP_ACT) && can_act_o[cmd_bank_i];
  assign acc_pre1 = (cmd_op_i == OP_PRE) && !cmd_ap_i && can_pre_o[cmd_bank_i];
  always_comb begin
    unique case (cmd_op_i)
      OP_NOP:       ok_now = 1'b1;
      OP_ACT:       ok_now = can_act_o[cmd_bank_i];
      OP_RD, OP_WR: ok_now = can_col_o[cmd_bank_i];
      OP_PRE:       ok_now = cmd_ap_i ? can_pre_all_o : can_pre_o[cmd_bank_i];
      default:      ok_now = 1'b0;
    endcase
  end

  AST_NO_ACT_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (can_act_o & bank_open_o) == '0); // R2
  AST_ACT_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_act |=> bank_open_o[$past(cmd_bank_i)]); // R2
  AST_COL_NEEDS_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((can_col_o | can_pre_o) & ~bank_open_o) == '0); // R3
  AST_PRE_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_pre1 |=> !bank_open_o[$past(cmd_bank_i)]); // R5
  AST_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ok_now |=> cmd_err_o); // R9
  AST_ERR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_now |=> !cmd_err_o); // R9

  if (T_RCD > 1) begin : g_rcd
    AST_RCD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc_act |=> !can_col_o[$past(cmd_bank_i)]); // R3
  end
  if (T_RRD > 1) begin : g_rrd
    AST_RRD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc_act |=> (can_act_o == '0)); // R4
  end
  if (T_RP > 1) begin : g_rp
    AST_RP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc_pre1 |=> !can_act_o[$past(cmd_bank_i)]); // R6
  end

endmodule

bind bank_timing_tracker bank_timing_tracker_chk #(
  .BANK_W(BANK_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_RRD(T_RRD)
) chk_i (.*);

// File: tb/bank_timing_tracker_tb_top.sv
`timescale 1ns/1ps
module bank_timing_tracker_tb_top;

  localparam int unsigned T_RCD = 3, T_RAS = 9, T_RP = 3, T_RRD = 2, CL = 2, BL = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] cmd_op_i = '0;
  logic [1:0] cmd_bank_i = '0;
  logic       cmd_ap_i = 1'b0;
  logic [3:0] bank_open_o, can_act_o, can_col_o, can_pre_o;
  logic       can_pre_all_o, cmd_err_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  bank_timing_tracker #(
    .BANK_W(2), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_RRD(T_RRD), .CL(CL), .BL(BL)
  ) dut_i (.*);

  // {op[2:0], bank[1:0], ap, expected error}
  localparam logic [6:0] VEC [0:36] = '{
    {3'd1, 2'd0, 1'b0, 1'b0},  //  0 open b0                      R2
    {3'd1, 2'd1, 1'b0, 1'b1},  //  1 open spacing too short       R4
    {3'd2, 2'd0, 1'b0, 1'b1},  //  2 read before row-to-col       R3
    {3'd2, 2'd0, 1'b0, 1'b0},  //  3 read on time                 R3
    {3'd4, 2'd0, 1'b0, 1'b1},  //  4 close too early              R5
    {3'd1, 2'd1, 1'b0, 1'b0},  //  5 open b1                      R4
    {3'd7, 2'd0, 1'b0, 1'b1},  //  6 bad opcode                   R9
    {3'd4, 2'd0, 1'b0, 1'b1},  //  7 active time not met          R5
    {3'd0, 2'd0, 1'b0, 1'b0},  //  8 nop                          R9
    {3'd4, 2'd0, 1'b0, 1'b0},  //  9 close b0                     R5
    {3'd1, 2'd0, 1'b0, 1'b1},  // 10 recovery                     R6
    {3'd1, 2'd0, 1'b0, 1'b1},  // 11 recovery                     R6
    {3'd1, 2'd0, 1'b0, 1'b0},  // 12 reopen b0                    R6
    {3'd1, 2'd2, 1'b0, 1'b1},  // 13 spacing                      R4
    {3'd3, 2'd1, 1'b0, 1'b0},  // 14 write b1                     R3
    {3'd2, 2'd0, 1'b1, 1'b0},  // 15 read b0 auto-close           R8
    {3'd4, 2'd0, 1'b1, 1'b1},  // 16 all-close while b0 waits     R7
    {3'd2, 2'd0, 1'b0, 1'b1},  // 17 read to waiting bank         R8
    {3'd4, 2'd1, 1'b0, 1'b0},  // 18 close b1                     R5
    {3'd1, 2'd2, 1'b0, 1'b0},  // 19 open b2                      R2
    {3'd1, 2'd0, 1'b0, 1'b1},  // 20 b0 still waiting             R8
    {3'd1, 2'd3, 1'b0, 1'b0},  // 21 open b3 (b0 closes here)     R4
    {3'd1, 2'd0, 1'b0, 1'b1},  // 22 recovery after auto-close    R8
    {3'd1, 2'd0, 1'b0, 1'b1},  // 23                              R6
    {3'd1, 2'd0, 1'b0, 1'b0},  // 24 postponed close ended at 21  R8
    {3'd3, 2'd2, 1'b0, 1'b0},  // 25 write b2                     R3
    {3'd4, 2'd3, 1'b0, 1'b1},  // 26 b3 active time               R5
    {3'd0, 2'd0, 1'b0, 1'b0},  // 27
    {3'd4, 2'd0, 1'b1, 1'b1},  // 28 all-close, b0 too young      R7
    {3'd0, 2'd0, 1'b0, 1'b0},  // 29
    {3'd0, 2'd0, 1'b0, 1'b0},  // 30
    {3'd0, 2'd0, 1'b0, 1'b0},  // 31
    {3'd0, 2'd0, 1'b0, 1'b0},  // 32
    {3'd4, 2'd3, 1'b1, 1'b0},  // 33 all-close ignores bank field R7
    {3'd1, 2'd1, 1'b0, 1'b0},  // 34 b1 was idle, not restarted   R7
    {3'd1, 2'd2, 1'b0, 1'b1},  // 35 spacing                      R4
    {3'd1, 2'd2, 1'b0, 1'b0}   // 36 b2 recovered                 R6
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic [2:0] op, input logic [1:0] bk, input logic ap);
    cmd_op_i = op; cmd_bank_i = bk; cmd_ap_i = ap;
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic do_reset();
    cmd_op_i = '0; cmd_bank_i = '0; cmd_ap_i = 1'b0;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    int close_k, act_k;
    do_reset();
    // R1 reset state
    chk(bank_open_o == 4'h0, "R1 open", bank_open_o, 4'h0);
    chk(can_act_o == 4'hf, "R1 can_act", can_act_o, 4'hf);
    chk(can_col_o == 4'h0 && can_pre_o == 4'h0, "R1 col/pre", {can_col_o, can_pre_o}, 8'h0);
    chk(cmd_err_o == 1'b0, "R1 err", cmd_err_o, 1'b0);

    for (int r = 0; r < 37; r++) begin
      step(VEC[r][6:4], VEC[r][3:2], VEC[r][1]);
      chk(cmd_err_o == VEC[r][0], $sformatf("R9 row %0d", r), cmd_err_o, VEC[r][0]);
    end
    chk(bank_open_o == 4'b0110, "R7 open after table", bank_open_o, 4'b0110);
    chk(can_act_o == 4'b0000, "R4 spacing blocks all", can_act_o, 4'b0000);
    step(3'd0, 2'd0, 1'b0);
    chk(can_act_o == 4'b1001, "R4 spacing over", can_act_o, 4'b1001);

    // R8 write with auto-close postponed by active time
    do_reset();
    step(3'd1, 2'd3, 1'b0);
    step(3'd0, 2'd0, 1'b0);
    step(3'd0, 2'd0, 1'b0);
    step(3'd3, 2'd3, 1'b1);
    chk(cmd_err_o == 1'b0, "R8 write accepted", cmd_err_o, 1'b0);
    chk(can_col_o[3] == 1'b0 && can_pre_o[3] == 1'b0, "R8 waiting bank blocked",
        {can_col_o[3], can_pre_o[3]}, 2'b00);
    close_k = 0; act_k = 0;
    for (int k = 1; k <= 8; k++) begin
      step(3'd0, 2'd0, 1'b0);
      if (close_k == 0 && !bank_open_o[3]) close_k = k;
      if (act_k == 0 && can_act_o[3]) act_k = k;
    end
    chk(close_k == 6, "R8 close cycle", close_k, 6);
    chk(act_k == 8, "R6 reopen after recovery", act_k, 8);

    // R5 earliest precharge after read, burst guard
    step(3'd1, 2'd1, 1'b0);
    repeat (9) step(3'd0, 2'd0, 1'b0);
    step(3'd2, 2'd1, 1'b0);
    chk(can_pre_o[1] == 1'b0, "R5 burst guard", can_pre_o[1], 1'b0);
    step(3'd4, 2'd1, 1'b0);
    chk(cmd_err_o == 1'b1, "R5 early close rejected", cmd_err_o, 1'b1);
    chk(bank_open_o[1] == 1'b1, "R9 no state change", bank_open_o[1], 1'b1);
    step(3'd4, 2'd1, 1'b0);
    chk(cmd_err_o == 1'b0, "R5 close at burst point", cmd_err_o, 1'b0);
    chk(bank_open_o[1] == 1'b0, "R5 bank closed", bank_open_o[1], 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule